// File: doc/BRIEF.md
# Selectable UART Baud Tick Generator

This block turns a free-running system clock into the two timing strobes that a serial receiver and transmitter need. A fixed prescaler divides the system clock (nominally 8 MHz) down to a base strobe. A binary counter then runs on that base strobe, and a 3-bit rate select picks one tap of the counter. The chosen tap produces a one-cycle enable at eight times the bit rate, for the receiver's oversampling. A further divide-by-8 stage produces a one-cycle enable at the bit rate, for the transmitter.

The prescale is a divide-by-13 stage followed by a divide-by-2 stage. The base strobe therefore arrives once every 26 system clocks, which is 307.69 kHz, or eight times 38462 baud. Each lower select value halves the rate. Select 7 gives the fastest rate (nominally 38400, really 38462 baud). Select 0 gives about 300.5 baud. Both strobes are ordinary clock enables in the system clock domain and are never used as clocks.

The rate select is sampled only on the base strobe. A change therefore takes effect at the next prescaler wrap and never creates a shortened strobe. After reset, the fastest rate is in force until that first wrap, whatever the select input holds.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is high, both ticks are low. After reset falls, counting cycles from the first rising edge with reset low as cycle 1, the first 8x tick is seen in cycle 25.
- R2: After reset, select value 7 (the fastest rate) is in force until the first base strobe, whatever `rate_sel_i` holds.
- R3: For a settled select value k (0..7), consecutive 8x ticks are exactly 26·2^(7−k) system clocks apart: 26 for k=7 and 3328 for k=0.
- R4: The 8x tick is never high in two consecutive cycles.
- R5: The 1x tick is high only together with an 8x tick. It marks every eighth 8x tick counted from reset, the first 1x tick being on the eighth 8x tick, so its spacing is eight times the 8x spacing.
- R6: `rate_sel_i` is sampled only in a cycle that carries a base strobe. A select change that is reverted before the next base strobe has no effect on tick timing.
- R7: Every 8x tick falls on a base strobe. The base strobe is the cycle in which the mod-13 prescale count is at 12 and the divide-by-2 phase is set, so with cycle numbering as in R1 the cycle number modulo 26 equals 25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (nominally 8 MHz) |
| rst_i | input | 1 | Synchronous active-high reset |
| rate_sel_i | input | 3 | Rate select, 0 = slowest (≈300 baud), 7 = fastest (≈38462 baud) |
| tick_x8_o | output | 1 | One-cycle enable at 8x the bit rate |
| tick_x1_o | output | 1 | One-cycle enable at the bit rate |

## Verification
All eight select values are swept from fastest to slowest. Each one waits two ticks to settle and then measures the 8x spacing, which separates every tap of the divider chain, including both ends of the range. For select values 7 down to 1, the bit-tick spacing is also measured, which shows the divide-by-8 stage runs on the chosen tap rather than on the base strobe. One run holds the slowest select through reset: it shows the fastest rate is in force until the first wrap, and that the select is then picked up there. A select glitch that is reverted between wraps must leave the fast spacing untouched, which tells sampling at the wrap apart from continuous sampling. A running monitor checks the phase of every tick, that no tick lasts two cycles, and that the 1x tick lines up with every eighth 8x tick.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

    // Default configuration of the tick generator
    localparam int unsigned DEF_PRESCALE = 13;
    localparam int unsigned DEF_SEL_W    = 3;
    localparam int unsigned DEF_OVS      = 8;

    // Named rate selections (nominal baud, 8 MHz system clock)
    typedef enum logic [DEF_SEL_W-1:0] {
        RATE_300   = 3'd0,
        RATE_600   = 3'd1,
        RATE_1200  = 3'd2,
        RATE_2400  = 3'd3,
        RATE_4800  = 3'd4,
        RATE_9600  = 3'd5,
        RATE_19200 = 3'd6,
        RATE_38400 = 3'd7
    } rate_sel_e;

    localparam rate_sel_e RATE_AFTER_RESET = RATE_38400;

    // Low-bit run length of the tap mask for a given select value
    function automatic int unsigned tap_run(input int unsigned nsel, input int unsigned k);
        return nsel - 1 - k;
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int unsigned PRESCALE = uart_baud_pkg::DEF_PRESCALE
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic wrap_o
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] cnt_q;
    logic             half_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (at_last) begin
            cnt_q  <= '0;
            half_q <= ~half_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Base strobe: end of the second prescale pass
    assign wrap_o = at_last && half_q;

    p_cnt_range_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);

    p_half_steps_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(at_last) |-> $stable(half_q));

endmodule

// File: rtl/baud_tap_divider.sv
module baud_tap_divider #(
    parameter int unsigned SEL_W = uart_baud_pkg::DEF_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wrap_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned NSEL  = 1 << SEL_W;
    localparam int unsigned TAP_W = (NSEL > 2) ? NSEL - 1 : 1;

    logic [TAP_W-1:0] dcnt_q;
    logic [SEL_W-1:0] active_q;
    logic [NSEL-1:0]  tap_hit;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dcnt_q   <= '0;
            active_q <= '1;
        end else if (wrap_i) begin
            dcnt_q   <= dcnt_q + 1'b1;
            active_q <= sel_i;
        end
    end

    // One tap per select value: divide ratio 2^(NSEL-1-k)
    for (genvar k = 0; k < NSEL; k++) begin : g_tap
        localparam int unsigned RUN = uart_baud_pkg::tap_run(NSEL, k);
        localparam logic [TAP_W-1:0] MASK = TAP_W'((64'd1 << RUN) - 64'd1);
        assign tap_hit[k] = ((dcnt_q & MASK) == MASK);
    end

    assign tick_o = wrap_i && tap_hit[active_q];

    p_sel_held_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(wrap_i) |-> $stable(active_q));

    p_tick_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o);

    p_count_on_wrap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(wrap_i) |-> $stable(dcnt_q));

endmodule

// File: rtl/baud_bit_divider.sv
module baud_bit_divider #(
    parameter int unsigned OVS = uart_baud_pkg::DEF_OVS
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_x8_i,
    output logic tick_x1_o
);
    localparam int unsigned BW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [BW-1:0] LAST = BW'(OVS - 1);

    logic [BW-1:0] bcnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bcnt_q <= '0;
        end else if (tick_x8_i) begin
            bcnt_q <= (bcnt_q == LAST) ? '0 : bcnt_q + 1'b1;
        end
    end

    assign tick_x1_o = tick_x8_i && (bcnt_q == LAST);

    p_bcnt_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(tick_x8_i) |-> $stable(bcnt_q));

    p_x1_single_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_x1_o |=> !tick_x1_o);

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int unsigned PRESCALE = uart_baud_pkg::DEF_PRESCALE,
    parameter int unsigned SEL_W    = uart_baud_pkg::DEF_SEL_W,
    parameter int unsigned OVS      = uart_baud_pkg::DEF_OVS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    output logic             tick_x8_o,
    output logic             tick_x1_o
);
    logic base_wrap;

    baud_prescaler #(.PRESCALE(PRESCALE)) i_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wrap_o (base_wrap)
    );

    baud_tap_divider #(.SEL_W(SEL_W)) i_tap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wrap_i (base_wrap),
        .sel_i  (rate_sel_i),
        .tick_o (tick_x8_o)
    );

    baud_bit_divider #(.OVS(OVS)) i_bit (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_x8_i (tick_x8_o),
        .tick_x1_o (tick_x1_o)
    );

    p_x8_on_wrap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_x8_o |-> base_wrap);

    p_x1_with_x8_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_x1_o |-> tick_x8_o);

    p_quiet_in_reset_r1: assert property (@(posedge clk_i)
        rst_i |=> (!tick_x8_o && !tick_x1_o) || !rst_i);

endmodule

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       tick8;
    logic       tick1;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int n8 = 0;
    int wd = 0;
    bit prev8 = 1'b0;
    bit mon_on = 1'b0;

    always #4 clk = ~clk;

    uart_baud_gen i_uart_baud_gen (
        .clk_i      (clk),
        .rst_i      (rst),
        .rate_sel_i (sel),
        .tick_x8_o  (tick8),
        .tick_x1_o  (tick1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One cycle: sample after the falling edge, then run the monitors
    task automatic step();
        @(negedge clk);
        cyc++;
        if (mon_on) begin
            if (tick8) begin
                n8++;
                check(!prev8, "R4", 1, 0);
                check(cyc % 26 == 25, "R7", cyc % 26, 25);
                check(int'(tick1) == int'(n8 % 8 == 0), "R5", int'(tick1), int'(n8 % 8 == 0));
            end else if (tick1) begin
                check(1'b0, "R5", 1, 0);
            end
        end
        prev8 = tick8;
    endtask

    task automatic wait_x8(output int at);
        do step(); while (!tick8);
        at = cyc;
    endtask

    task automatic wait_x1(output int at);
        do step(); while (!tick1);
        at = cyc;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        int t0, t1, u0, u1;
        // R1: quiet during reset, slowest select held to probe R2
        sel = 3'd0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!tick8 && !tick1, "R1", int'(tick8) + int'(tick1), 0);
        end
        rst = 1'b0;
        cyc = 0;
        mon_on = 1'b1;
        check(!tick8, "R1", int'(tick8), 0);

        // R1/R2: first tick at cycle 25 under the fastest rate
        wait_x8(t0);
        check(t0 == 25, "R1", t0, 25);
        check(t0 == 25, "R2", t0, 25);
        // R6/R3: select 0 picked up at that wrap, next tick after 127 strobes
        wait_x8(t1);
        check(t1 == 25 + 26 * 127, "R6", t1, 25 + 26 * 127);

        // R3/R5: sweep every select value
        for (int k = 7; k >= 0; k--) begin
            sel = 3'(k);
            wait_x8(t0);
            wait_x8(t0);
            wait_x8(t1);
            check(t1 - t0 == (26 << (7 - k)), "R3", t1 - t0, 26 << (7 - k));
            if (k >= 1) begin
                wait_x1(u0);
                wait_x1(u1);
                check(u1 - u0 == (208 << (7 - k)), "R5", u1 - u0, 208 << (7 - k));
            end
        end

        // R6: glitch on select reverted between two wraps
        sel = 3'd7;
        wait_x8(t0);
        wait_x8(t0);
        for (int i = 0; i < 3; i++) step();
        sel = 3'd0;
        for (int i = 0; i < 5; i++) step();
        sel = 3'd7;
        wait_x8(t1);
        check(t1 - t0 == 26, "R6", t1 - t0, 26);
        wait_x8(t0);
        check(t0 - t1 == 26, "R6", t0 - t1, 26);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule